// File: doc/BRIEF.md
# Scratchpad Read Address Generator

This block turns one decoded instruction per valid cycle into a scratchpad read address for operand A. It keeps eight 64-bit integer registers and a 32-bit mix register. A three-bit field of the register byte picks the source register. The 32-bit mask is sign-extended and XORed into that register, and the new value is written back to the same register. The low 32 bits of the new value form the read address.

Generating an address has side effects beyond the address itself. The mix register can absorb the full 32-bit address. A dataset-read request is raised when the instruction counter is aligned to 64. The address is then cut to a wide (15-bit) or narrow (11-bit) word address. A load port fills the register file before or between instructions. All results appear on registered outputs one cycle after the valid pulse.

Top module: `spad_raddr_gen`

## Requirements
- R1: Bits 2:0 of `reg_sel_i` choose the address register r0..r7. Bits 7:3 have no effect on any output.
- R2: The chosen register is replaced by its old value XOR `{ {32{mask_i[31]}}, mask_i }`. `upd_val_o` shows the new 64-bit value.
- R3: `raw_addr_o` equals bits 31:0 of the updated register value.
- R4: `ds_req_o` is high for the result cycle if and only if `icnt_i[5:0]` is zero.
- R5: When `loc_i[7:6]` is 2'b00, the mix register becomes mix XOR the full 32-bit address. Otherwise it keeps its value. `mix_o` shows the register.
- R6: When `loc_i[1:0]` is 0, `addr_o` is address bits 14:0 and `narrow_o` is 0. When it is nonzero, `addr_o` is address bits 10:0 zero-padded to 15 bits and `narrow_o` is 1.
- R7: `loc_i[5:2]` has no effect on any output.
- R8: All results are registered. `res_valid_o` pulses exactly one cycle after `valid_i`.
- R9: An active-low asynchronous reset clears all registers, the mix register and every output to zero.
- R10: The load port writes `ld_data_i` into register `ld_idx_i` when `ld_en_i` is high and `valid_i` is low. A load in a cycle that also has `valid_i` high is dropped.
- R11: An instruction in the cycle right after another instruction on the same register uses the value written back by the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction fields are valid |
| loc_i | input | 8 | Location byte: width field [1:0], mix-disable field [7:6] |
| reg_sel_i | input | 8 | Register byte, index in [2:0] |
| mask_i | input | 32 | Address mask |
| icnt_i | input | 32 | Instruction counter |
| ld_en_i | input | 1 | Register load enable |
| ld_idx_i | input | 3 | Register load index |
| ld_data_i | input | 64 | Register load data |
| res_valid_o | output | 1 | Results valid |
| addr_o | output | 15 | Truncated read address |
| narrow_o | output | 1 | 11-bit address in use |
| raw_addr_o | output | 32 | Untruncated read address |
| ds_req_o | output | 1 | Dataset read request |
| upd_val_o | output | 64 | Written-back register value |
| mix_o | output | 32 | Mix register |

## Verification
A corrupted register-file entry has no effect until an instruction reads that register. It then appears at once on `raw_addr_o` and `upd_val_o` in that instruction's result cycle. A wrong mix update, by contrast, stays in the mix register and shows on `mix_o` one cycle after the instruction that caused it. The bench therefore follows every instruction with a full compare and chains instructions that reuse registers. This exposes a lost write-back or a dropped load on the next read of that register.

// File: rtl/spad_ag_pkg.sv
package spad_ag_pkg;
  localparam int unsigned XLEN     = 64;
  localparam int unsigned MASK_W   = 32;
  localparam int unsigned NREG     = 8;
  localparam int unsigned IDX_W    = $clog2(NREG);
  localparam int unsigned AW_WIDE  = 15;
  localparam int unsigned AW_NARW  = 11;
  localparam int unsigned DS_LOG2  = 6;

  typedef struct packed {
    logic [AW_WIDE-1:0] addr;
    logic               narrow;
    logic [MASK_W-1:0]  raw;
    logic               ds;
    logic [XLEN-1:0]    upd;
  } ag_res_t;
endpackage

// File: rtl/ag_regfile.sv
module ag_regfile #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned XLEN  = 64,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [XLEN-1:0]  rd_data_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i
);
  logic [XLEN-1:0] rf_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     rf_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))        rf_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = rf_q[rd_idx_i];

  // write lands in the addressed entry (R10, R2)
  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> rf_q[$past(wr_idx_i)] == $past(wr_data_i));
endmodule

// File: rtl/ag_addr_calc.sv
module ag_addr_calc
  import spad_ag_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic [7:0]        loc_i,
  input  logic [7:0]        reg_sel_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic [CNT_W-1:0]  icnt_i,
  input  logic [XLEN-1:0]   reg_val_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              mix_en_o,
  output ag_res_t           res_o
);
  logic [XLEN-1:0]   mask_sx;
  logic [XLEN-1:0]   upd;
  logic [MASK_W-1:0] raw;
  logic              narrow;

  assign idx_o    = reg_sel_i[IDX_W-1:0];
  assign mask_sx  = {{(XLEN-MASK_W){mask_i[MASK_W-1]}}, mask_i};
  assign upd      = reg_val_i ^ mask_sx;
  assign raw      = upd[MASK_W-1:0];
  assign narrow   = (loc_i[1:0] != 2'b00);
  assign mix_en_o = (loc_i[7:6] == 2'b00);

  always_comb begin
    res_o        = '0;
    res_o.upd    = upd;
    res_o.raw    = raw;
    res_o.narrow = narrow;
    res_o.ds     = (icnt_i[DS_LOG2-1:0] == '0);
    if (narrow) res_o.addr = {{(AW_WIDE-AW_NARW){1'b0}}, raw[AW_NARW-1:0]};
    else        res_o.addr = raw[AW_WIDE-1:0];
  end
endmodule

// File: rtl/spad_raddr_gen.sv
module spad_raddr_gen
  import spad_ag_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [7:0]          loc_i,
  input  logic [7:0]          reg_sel_i,
  input  logic [MASK_W-1:0]   mask_i,
  input  logic [CNT_W-1:0]    icnt_i,
  input  logic                ld_en_i,
  input  logic [IDX_W-1:0]    ld_idx_i,
  input  logic [XLEN-1:0]     ld_data_i,
  output logic                res_valid_o,
  output logic [AW_WIDE-1:0]  addr_o,
  output logic                narrow_o,
  output logic [MASK_W-1:0]   raw_addr_o,
  output logic                ds_req_o,
  output logic [XLEN-1:0]     upd_val_o,
  output logic [MASK_W-1:0]   mix_o
);
  logic [IDX_W-1:0]  sel_idx;
  logic [XLEN-1:0]   sel_val;
  logic              mix_en;
  ag_res_t           res_d, res_q;
  logic              vld_q;
  logic [MASK_W-1:0] mix_q;
  logic              we;
  logic [IDX_W-1:0]  wr_idx;
  logic [XLEN-1:0]   wr_data;

  ag_addr_calc #(.CNT_W(CNT_W)) u_calc (
    .loc_i     (loc_i),
    .reg_sel_i (reg_sel_i),
    .mask_i    (mask_i),
    .icnt_i    (icnt_i),
    .reg_val_i (sel_val),
    .idx_o     (sel_idx),
    .mix_en_o  (mix_en),
    .res_o     (res_d)
  );

  // instruction write-back wins over the load port
  assign we      = valid_i | ld_en_i;
  assign wr_idx  = valid_i ? sel_idx   : ld_idx_i;
  assign wr_data = valid_i ? res_d.upd : ld_data_i;

  ag_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (sel_idx),
    .rd_data_o (sel_val),
    .we_i      (we),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
      mix_q <= '0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) begin
        res_q <= res_d;
        if (mix_en) mix_q <= mix_q ^ res_d.raw;
      end else begin
        res_q.ds <= 1'b0;
      end
    end
  end

  assign res_valid_o = vld_q;
  assign addr_o      = res_q.addr;
  assign narrow_o    = res_q.narrow;
  assign raw_addr_o  = res_q.raw;
  assign ds_req_o    = res_q.ds;
  assign upd_val_o   = res_q.upd;
  assign mix_o       = mix_q;

  assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(valid_i));
  assert_ds_needs_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ds_req_o |-> res_valid_o);
  assert_mix_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mix_o));
  assert_narrow_pad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && narrow_o) |-> (addr_o[AW_WIDE-1:AW_NARW] == '0));
  assert_addr_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (addr_o[AW_NARW-1:0] == raw_addr_o[AW_NARW-1:0]));
endmodule

// File: tb/spad_raddr_gen_tb_top.sv
module spad_raddr_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [7:0]  loc_i = '0;
  logic [7:0]  reg_sel_i = '0;
  logic [31:0] mask_i = '0;
  logic [31:0] icnt_i = '0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_idx_i = '0;
  logic [63:0] ld_data_i = '0;
  logic        res_valid_o, narrow_o, ds_req_o;
  logic [14:0] addr_o;
  logic [31:0] raw_addr_o, mix_o;
  logic [63:0] upd_val_o;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_rf [8];
  logic [31:0] m_mix;

  always #10 clk_i = ~clk_i;

  spad_raddr_gen dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_rf[i] = '0;
    m_mix = '0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0; ld_en_i = 1'b0;
    model_clear();
    @(negedge clk_i);
    chk("R9 valid", {63'd0, res_valid_o}, 64'd0);
    chk("R9 mix", {32'd0, mix_o}, 64'd0);
    chk("R9 upd", upd_val_o, 64'd0);
    chk("R9 addr", {49'd0, addr_o}, 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic load(input logic [2:0] idx, input logic [63:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_idx_i = idx; ld_data_i = d;
    m_rf[idx] = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
  endtask

  // drive at current negedge; caller advances
  task automatic drive(input logic [7:0] loc, input logic [7:0] rs, input logic [31:0] m,
                       input logic [31:0] ic, output logic [63:0] e_upd, output logic [14:0] e_addr,
                       output logic e_nar, output logic e_ds);
    logic [2:0] ix;
    ix = rs[2:0];
    valid_i = 1'b1; loc_i = loc; reg_sel_i = rs; mask_i = m; icnt_i = ic;
    e_upd = m_rf[ix] ^ {{32{m[31]}}, m};
    m_rf[ix] = e_upd;
    if (loc[7:6] == 2'b00) m_mix = m_mix ^ e_upd[31:0];
    e_nar = (loc[1:0] != 2'b00);
    e_addr = e_nar ? {4'd0, e_upd[10:0]} : e_upd[14:0];
    e_ds = (ic[5:0] == 6'd0);
  endtask

  task automatic verify(input string tag, input logic [63:0] e_upd, input logic [14:0] e_addr,
                        input logic e_nar, input logic e_ds);
    chk({tag, " R8 valid"}, {63'd0, res_valid_o}, 64'd1);
    chk({tag, " R2 upd"}, upd_val_o, e_upd);
    chk({tag, " R3 raw"}, {32'd0, raw_addr_o}, {32'd0, e_upd[31:0]});
    chk({tag, " R6 addr"}, {49'd0, addr_o}, {49'd0, e_addr});
    chk({tag, " R6 narrow"}, {63'd0, narrow_o}, {63'd0, e_nar});
    chk({tag, " R4 ds"}, {63'd0, ds_req_o}, {63'd0, e_ds});
    chk({tag, " R5 mix"}, {32'd0, mix_o}, {32'd0, m_mix});
  endtask

  task automatic instr(input string tag, input logic [7:0] loc, input logic [7:0] rs,
                       input logic [31:0] m, input logic [31:0] ic);
    logic [63:0] eu; logic [14:0] ea; logic en, ed;
    @(negedge clk_i);
    drive(loc, rs, m, ic, eu, ea, en, ed);
    @(negedge clk_i);
    valid_i = 1'b0;
    verify(tag, eu, ea, en, ed);
    @(negedge clk_i);
    chk({tag, " R8 pulse"}, {63'd0, res_valid_o}, 64'd0);
    chk({tag, " R4 ds drop"}, {63'd0, ds_req_o}, 64'd0);
  endtask

  task automatic t_basic();
    load(3'd1, 64'h0123_4567_89AB_CDEF);
    instr("basic_pos_mask", 8'h00, 8'h01, 32'h0000_1234, 32'd64);
    instr("basic_neg_mask", 8'h00, 8'h01, 32'h8000_00F0, 32'd65);
  endtask

  task automatic t_sel_ignore_R1();
    load(3'd5, 64'hFFFF_0000_AAAA_5555);
    instr("R1 high bits", 8'h00, 8'hF5, 32'h0000_0001, 32'd3);
  endtask

  task automatic t_width_R6();
    load(3'd2, 64'h0000_0000_DEAD_BEEF);
    instr("R6 w1", 8'h01, 8'h02, 32'h0, 32'd128);
    instr("R6 w2", 8'h02, 8'h02, 32'h7FFF, 32'd7);
    instr("R6 w3", 8'h03, 8'h02, 32'h1, 32'd0);
  endtask

  task automatic t_mix_R5();
    load(3'd6, 64'h1111_2222_3333_4444);
    instr("R5 no mix 01", 8'h40, 8'h06, 32'h5, 32'd1);
    instr("R5 no mix 10", 8'h80, 8'h06, 32'h6, 32'd2);
    instr("R5 no mix 11", 8'hC0, 8'h06, 32'h7, 32'd64);
    instr("R5 mix", 8'h00, 8'h06, 32'hCAFE_0000, 32'd9);
  endtask

  task automatic t_reserved_R7();
    load(3'd7, 64'h0000_0000_0000_7FFF);
    instr("R7 reserved set", 8'h3C, 8'h07, 32'h0000_4000, 32'd10);
    instr("R7 reserved mix", 8'h3D, 8'h07, 32'h0, 32'd192);
  endtask

  task automatic t_load_drop_R10();
    logic [63:0] eu; logic [14:0] ea; logic en, ed;
    load(3'd4, 64'hAAAA_BBBB_CCCC_DDDD);
    @(negedge clk_i);
    drive(8'h00, 8'h03, 32'h1, 32'd5, eu, ea, en, ed);
    ld_en_i = 1'b1; ld_idx_i = 3'd4; ld_data_i = 64'h5; // dropped, model untouched
    @(negedge clk_i);
    valid_i = 1'b0; ld_en_i = 1'b0;
    verify("R10 colliding", eu, ea, en, ed);
    instr("R10 dropped load", 8'h00, 8'h04, 32'h0, 32'd6);
  endtask

  task automatic t_b2b_R11();
    logic [63:0] eu; logic [14:0] ea; logic en, ed;
    load(3'd0, 64'h0000_0000_0000_00FF);
    @(negedge clk_i);
    drive(8'h00, 8'h00, 32'h0000_0F00, 32'd1, eu, ea, en, ed);
    @(negedge clk_i);
    verify("R11 first", eu, ea, en, ed);
    drive(8'h00, 8'h08, 32'hFFFF_F00F, 32'd0, eu, ea, en, ed);
    @(negedge clk_i);
    valid_i = 1'b0;
    verify("R11 second", eu, ea, en, ed);
  endtask

  task automatic t_reset_R9();
    load(3'd3, 64'h1234_5678_9ABC_DEF0);
    instr("pre reset", 8'h00, 8'h03, 32'h1, 32'd1);
    do_reset();
    instr("R9 cleared reg", 8'h00, 8'h03, 32'h0, 32'd1);
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk_i);
    chk("R9 init valid", {63'd0, res_valid_o}, 64'd0);
    chk("R9 init mix", {32'd0, mix_o}, 64'd0);
    rst_ni = 1'b1;
    t_basic();
    t_sel_ignore_R1();
    t_width_R6();
    t_mix_R5();
    t_reserved_R7();
    t_load_drop_R10();
    t_b2b_R11();
    t_reset_R9();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule